// File: doc/BRIEF.md
# Dual-Timer Capture/Compare Unit

The unit holds two up-counting 16-bit timers and a bank of capture/compare channels. Each timer has a reload register. A timer advances on every clock or on rising edges of its own external count input. When it passes 0xFFFF it restarts from the reload value and raises a timer flag. Each channel is tied to one of the two timers. It either stamps that timer's value when an edge arrives on its capture input, or compares the timer against its own value register to raise a flag and shape a pulse-width waveform on its output pin.

Four compare behaviours are offered. Two of them act on every match in a period: flag only, or flag plus pin toggle. The other two act on the first match only: flag only, or flag plus pin set, with the pin cleared again at the timer wrap. An even channel in the toggle mode can also take toggles from its odd neighbour when that neighbour is in the flag-only mode, so two thresholds shape one pin. Some channels are built as capture-only. Software reaches every register through one address bus with a write strobe and a combinational read port.

Top module: `ccu_top`

## Requirements
- R1: A timer with its run bit (ctrl bit 2t) set counts every clock when its source bit (ctrl bit 2t+1) is 0. When the source bit is 1 it counts exactly once per rising edge of ext_clk_i[t], however long the input stays high.
- R2: A step taken at 0xFFFF loads the timer's reload value and sets tmr_flag_o[t].
- R3: Channel cfg bit 3 picks the timer (0 or 1). A channel reacts only to steps of its selected timer.
- R4: Mode code 2 sets the channel flag on every match with no pin action, including a second match in the same period.
- R5: Mode code 3 inverts the channel pin and sets its flag on every match.
- R6: Mode code 4 sets the flag on the first match after a wrap only; a channel is armed out of reset.
- R7: Mode code 5 sets the flag and drives the pin high on the first match in a period, and clears the pin at the wrap. When the reload value itself matches, the pin ends high.
- R8: With cfg bit 6 set on an even channel in mode 3, a mode-2 match on the next odd channel also toggles the even channel's pin, once per cycle. The odd pin is not driven.
- R9: Mode code 1 latches the selected timer value on the edges enabled by cfg bit 4 (rising) and bit 5 (falling), and sets the flag. A capture beats a software write to the same value register in the same cycle.
- R10: Capture-only channels (CAP_ONLY_MASK) neither move their pin nor set their flag in compare modes.
- R11: A write to address 5 clears each channel flag whose bit in wdata[N_CH-1:0] is 1, and each timer flag whose bit in wdata[N_CH+1:N_CH] is 1. Other flags are kept.
- R12: Out of reset, all counters, reload, config and value registers, flags and pins are zero.

A match is a timer step whose new count equals the channel value. A value written mid-period is used at the next step. Address map: addr[4:3]=0 selects timer registers (index 0/1 reload, 2/3 count, 4 control, 5 flags), 2 selects channel config and 3 selects channel value, with the channel number in addr[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for write and read |
| wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for addr_i |
| ext_clk_i | input | 2 | External count inputs, one per timer |
| cap_i | input | N_CH | Capture inputs |
| cmp_o | output | N_CH | Compare output pins |
| ch_flag_o | output | N_CH | Channel event flags |
| tmr_flag_o | output | 2 | Timer wrap flags |

## Verification
In the set-on-match mode, the timer wrap and a compare match land in the same cycle when the channel value equals the reload value. The wrap asks for the pin to be cleared and the match asks for it to be set. The bench steps the timer from 0xFFFF with both values at 0x0010 and requires the pin high, the flag set and the count at 0x0010. A second collision is a capture edge arriving in the cycle of a software write to the same value register. The bench requires the timer value, not the written value, to be read back.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic [2:0] {
    CM_OFF  = 3'd0,
    CM_CAP  = 3'd1,
    CM_CMP0 = 3'd2,
    CM_CMP1 = 3'd3,
    CM_CMP2 = 3'd4,
    CM_CMP3 = 3'd5
  } ccu_mode_e;

  localparam int unsigned CfgW     = 7;
  localparam int unsigned CfgTsel  = 3;
  localparam int unsigned CfgRise  = 4;
  localparam int unsigned CfgFall  = 5;
  localparam int unsigned CfgPair  = 6;
endpackage

// File: rtl/ccu_timer.sv
module ccu_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rld_we_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         run_i,
  input  logic         ext_sel_i,
  input  logic         ext_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         step_o,
  output logic         ovf_o,
  output logic         flag_o
);
  localparam logic [W-1:0] MaxCnt = '1;

  logic ext_q, tick;
  assign tick = run_i && (!ext_sel_i || (ext_i && !ext_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= 1'b0;
      cnt_o  <= '0;
      rld_o  <= '0;
      step_o <= 1'b0;
      ovf_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      ext_q <= ext_i;
      if (rld_we_i) rld_o <= wdata_i;
      if (cnt_we_i) begin
        cnt_o  <= wdata_i;
        step_o <= 1'b0;
        ovf_o  <= 1'b0;
      end else if (tick) begin
        step_o <= 1'b1;
        ovf_o  <= (cnt_o == MaxCnt);
        cnt_o  <= (cnt_o == MaxCnt) ? rld_o : cnt_o + 1'b1;
      end else begin
        step_o <= 1'b0;
        ovf_o  <= 1'b0;
      end
      if (tick && !cnt_we_i && cnt_o == MaxCnt) flag_o <= 1'b1;
      else if (clr_i)                           flag_o <= 1'b0;
    end
  end

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_we_i && cnt_o == MaxCnt) |=> (cnt_o == $past(rld_o) && flag_o && ovf_o));
endmodule

// File: rtl/ccu_chan.sv
module ccu_chan
  import ccu_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter bit          CAN_CMP = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic            val_we_i,
  input  logic [W-1:0]    wdata_i,
  input  logic [W-1:0]    cnt_i,
  input  logic            step_i,
  input  logic            ovf_i,
  input  logic            cap_i,
  input  logic            pair_hit_i,
  input  logic            clr_i,
  output logic [CfgW-1:0] cfg_o,
  output logic [W-1:0]    val_o,
  output logic            flag_o,
  output logic            pin_o,
  output logic            m0_hit_o
);
  ccu_mode_e mode;
  logic cap_q, armed_q, is_cmp, one_shot, match, evt, cap_evt, pair_tog;

  assign mode     = ccu_mode_e'(cfg_o[2:0]);
  assign is_cmp   = mode inside {CM_CMP0, CM_CMP1, CM_CMP2, CM_CMP3};
  assign one_shot = mode inside {CM_CMP2, CM_CMP3};
  assign match    = CAN_CMP && is_cmp && step_i && (cnt_i == val_o);
  assign evt      = match && (!one_shot || armed_q || ovf_i);
  assign m0_hit_o = evt && (mode == CM_CMP0);
  assign pair_tog = CAN_CMP && cfg_o[CfgPair] && pair_hit_i;
  assign cap_evt  = (mode == CM_CAP) &&
                    ((cfg_o[CfgRise] && cap_i && !cap_q) ||
                     (cfg_o[CfgFall] && !cap_i && cap_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= 1'b0;
      armed_q <= 1'b1;
      cfg_o   <= '0;
      val_o   <= '0;
      flag_o  <= 1'b0;
      pin_o   <= 1'b0;
    end else begin
      cap_q <= cap_i;
      if (cfg_we_i) cfg_o <= wdata_i[CfgW-1:0];
      if (cap_evt)       val_o <= cnt_i;
      else if (val_we_i) val_o <= wdata_i;
      if (evt && one_shot) armed_q <= 1'b0;
      else if (ovf_i)      armed_q <= 1'b1;
      if (evt || cap_evt) flag_o <= 1'b1;
      else if (clr_i)     flag_o <= 1'b0;
      unique case (mode)
        CM_CMP1: if (evt || pair_tog) pin_o <= ~pin_o;
        CM_CMP3: if (evt) pin_o <= 1'b1; else if (ovf_i) pin_o <= 1'b0;
        default: ;
      endcase
    end
  end

  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CM_CMP1 && evt) |=> (pin_o != $past(pin_o)));
  p_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_shot && evt) |=> !armed_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CM_CMP3 && ovf_i && !evt) |=> !pin_o);
  p_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (val_o == $past(cnt_i) && flag_o));
  p_caponly_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!CAN_CMP && is_cmp) |=> $stable(pin_o));
endmodule

// File: rtl/ccu_top.sv
module ccu_top
  import ccu_pkg::*;
#(
  parameter int unsigned     W             = 16,
  parameter int unsigned     N_CH          = 4,
  parameter logic [N_CH-1:0] CAP_ONLY_MASK = 4'b1100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [4:0]      addr_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    rd_data_o,
  input  logic [1:0]      ext_clk_i,
  input  logic [N_CH-1:0] cap_i,
  output logic [N_CH-1:0] cmp_o,
  output logic [N_CH-1:0] ch_flag_o,
  output logic [1:0]      tmr_flag_o
);
  localparam int unsigned NT = 2;
  localparam logic [1:0] SelTmr = 2'd0, SelCfg = 2'd2, SelVal = 2'd3;

  logic [1:0] sel;
  logic [2:0] idx;
  assign sel = addr_i[4:3];
  assign idx = addr_i[2:0];

  logic [2*NT-1:0] ctrl_q;
  logic            ctrl_we, clr_we;
  assign ctrl_we = wr_en_i && sel == SelTmr && idx == 3'd4;
  assign clr_we  = wr_en_i && sel == SelTmr && idx == 3'd5;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata_i[2*NT-1:0];
  end

  logic [W-1:0]  t_cnt [NT];
  logic [W-1:0]  t_rld [NT];
  logic [NT-1:0] t_step, t_ovf;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    ccu_timer #(.W(W)) i_tmr (
      .clk_i, .rst_ni,
      .rld_we_i (wr_en_i && sel == SelTmr && idx == 3'(t)),
      .cnt_we_i (wr_en_i && sel == SelTmr && idx == 3'(t + 2)),
      .wdata_i,
      .run_i    (ctrl_q[2*t]),
      .ext_sel_i(ctrl_q[2*t+1]),
      .ext_i    (ext_clk_i[t]),
      .clr_i    (clr_we && wdata_i[N_CH+t]),
      .cnt_o    (t_cnt[t]),
      .rld_o    (t_rld[t]),
      .step_o   (t_step[t]),
      .ovf_o    (t_ovf[t]),
      .flag_o   (tmr_flag_o[t])
    );
  end

  logic [CfgW-1:0] c_cfg [N_CH];
  logic [W-1:0]    c_val [N_CH];
  logic [N_CH-1:0] m0_hit, pair_hit;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic ts;
    assign ts = c_cfg[k][CfgTsel];
    if (k % 2 == 0 && k + 1 < N_CH) begin : g_pair
      assign pair_hit[k] = m0_hit[k+1];
    end else begin : g_nopair
      assign pair_hit[k] = 1'b0;
    end
    ccu_chan #(.W(W), .CAN_CMP(!CAP_ONLY_MASK[k])) i_ch (
      .clk_i, .rst_ni,
      .cfg_we_i  (wr_en_i && sel == SelCfg && idx == 3'(k)),
      .val_we_i  (wr_en_i && sel == SelVal && idx == 3'(k)),
      .wdata_i,
      .cnt_i     (ts ? t_cnt[1] : t_cnt[0]),
      .step_i    (ts ? t_step[1] : t_step[0]),
      .ovf_i     (ts ? t_ovf[1] : t_ovf[0]),
      .cap_i     (cap_i[k]),
      .pair_hit_i(pair_hit[k]),
      .clr_i     (clr_we && wdata_i[k]),
      .cfg_o     (c_cfg[k]),
      .val_o     (c_val[k]),
      .flag_o    (ch_flag_o[k]),
      .pin_o     (cmp_o[k]),
      .m0_hit_o  (m0_hit[k])
    );
  end

  always_comb begin
    rd_data_o = '0;
    unique case (sel)
      SelTmr: begin
        unique case (idx)
          3'd0:    rd_data_o = t_rld[0];
          3'd1:    rd_data_o = t_rld[1];
          3'd2:    rd_data_o = t_cnt[0];
          3'd3:    rd_data_o = t_cnt[1];
          3'd4:    rd_data_o = W'(ctrl_q);
          3'd5:    rd_data_o = W'({tmr_flag_o, ch_flag_o});
          default: rd_data_o = '0;
        endcase
      end
      SelCfg: for (int k = 0; k < N_CH; k++) if (idx == 3'(k)) rd_data_o = W'(c_cfg[k]);
      SelVal: for (int k = 0; k < N_CH; k++) if (idx == 3'(k)) rd_data_o = c_val[k];
      default: rd_data_o = '0;
    endcase
  end

  p_flagclr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we && wdata_i[0] && !cmp_o[0] && $stable(cmp_o[0]) && ch_flag_o[0] && !t_step[0] && !t_step[1] && c_cfg[0][2:0] != 3'd1)
    |=> !ch_flag_o[0]);
endmodule

// File: tb/test_ccu_top.sv
`timescale 1ns/1ps
module test_ccu_top;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0] ext = '0;
  logic [N-1:0] cap = '0, cmp, chf;
  logic [1:0] tf;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ccu_top i_ccu_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rd_data_o(rdata), .ext_clk_i(ext), .cap_i(cap), .cmp_o(cmp),
    .ch_flag_o(chf), .tmr_flag_o(tf)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] val, start, rld;
    logic [7:0]  steps;
    logic [15:0] ecnt;
    logic        eflag, epin, etf;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd2, 16'h0005, 16'h0003, 16'h0000, 8'd2,  16'h0005, 1'b1, 1'b0, 1'b0}, // R4
    '{3'd3, 16'h0005, 16'h0003, 16'h0000, 8'd2,  16'h0005, 1'b1, 1'b1, 1'b0}, // R5
    '{3'd3, 16'h0005, 16'h0003, 16'h0000, 8'd1,  16'h0004, 1'b0, 1'b0, 1'b0}, // R5
    '{3'd3, 16'hFFF0, 16'hFFEF, 16'hFFEF, 8'd18, 16'hFFF0, 1'b1, 1'b0, 1'b1}, // R5 R2
    '{3'd5, 16'h0005, 16'h0003, 16'h0000, 8'd3,  16'h0006, 1'b1, 1'b1, 1'b0}, // R7
    '{3'd5, 16'hFFFD, 16'hFFFB, 16'hFFFC, 8'd5,  16'hFFFC, 1'b1, 1'b0, 1'b1}, // R7
    '{3'd5, 16'h0010, 16'hFFFF, 16'h0010, 8'd1,  16'h0010, 1'b1, 1'b1, 1'b1}, // R7
    '{3'd4, 16'h0005, 16'h0003, 16'h0000, 8'd2,  16'h0005, 1'b1, 1'b0, 1'b0}, // R6
    '{3'd0, 16'h0005, 16'h0003, 16'h0000, 8'd2,  16'h0005, 1'b0, 1'b0, 1'b0}, // R12 off
    '{3'd4, 16'h0007, 16'h0003, 16'h0000, 8'd2,  16'h0005, 1'b0, 1'b0, 1'b0}  // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(input int t);
    ext[t] = 1'b1;
    @(negedge clk);
    ext[t] = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 pins", cmp, 0);
    chk("R12 flags", {tf, chf}, 0);
    rd(5'd2, r);  chk("R12 cnt0", r, 0);
    rd(5'd16, r); chk("R12 cfg0", r, 0);
    rd(5'd24, r); chk("R12 val0", r, 0);

    // table of compare scenarios on channel 0, timer 0 stepped externally
    for (int i = 0; i < 10; i++) begin
      do_reset();
      wr(5'd0, VECS[i].rld);
      wr(5'd2, VECS[i].start);
      wr(5'd16, {13'd0, VECS[i].mode});
      wr(5'd24, VECS[i].val);
      wr(5'd4, 16'h0003);
      for (int s = 0; s < int'(VECS[i].steps); s++) step(0);
      rd(5'd2, r);
      chk($sformatf("R1 R2 vec%0d cnt", i), r, VECS[i].ecnt);
      chk($sformatf("R4 R5 R6 R7 vec%0d flag", i), chf[0], VECS[i].eflag);
      chk($sformatf("R5 R7 vec%0d pin", i), cmp[0], VECS[i].epin);
      chk($sformatf("R2 vec%0d tflag", i), tf[0], VECS[i].etf);
    end

    // R6 / R4 / R11: one event per period versus every match
    do_reset();
    wr(5'd16, 16'h0004); wr(5'd24, 16'h0005);
    wr(5'd17, 16'h0002); wr(5'd25, 16'h0005);
    wr(5'd2, 16'h0003); wr(5'd4, 16'h0003);
    step(0); step(0);
    chk("R6 first match", chf[0], 1);
    chk("R4 first match", chf[1], 1);
    wr(5'd5, 16'h0001);
    chk("R11 clear ch0", chf[0], 0);
    chk("R11 keep ch1", chf[1], 1);
    wr(5'd5, 16'h0002);
    chk("R11 clear ch1", chf[1], 0);
    wr(5'd2, 16'h0003);
    step(0); step(0);
    chk("R6 second match ignored", chf[0], 0);
    chk("R4 second match flags", chf[1], 1);
    wr(5'd2, 16'hFFFF);
    step(0);
    chk("R2 wrap flag", tf[0], 1);
    wr(5'd2, 16'h0003);
    step(0); step(0);
    chk("R6 rearmed after wrap", chf[0], 1);

    // R3 timer selection
    do_reset();
    wr(5'd16, 16'h000B); wr(5'd24, 16'h0005);
    wr(5'd2, 16'h0003); wr(5'd3, 16'h0004); wr(5'd4, 16'h000F);
    step(0); step(0);
    chk("R3 other timer ignored", cmp[0], 0);
    step(1);
    chk("R3 own timer toggles", cmp[0], 1);

    // R8 double register, R10 capture-only
    do_reset();
    wr(5'd16, 16'h0043); wr(5'd24, 16'h0005);
    wr(5'd17, 16'h0002); wr(5'd25, 16'h0007);
    wr(5'd18, 16'h0003); wr(5'd26, 16'h0005);
    wr(5'd2, 16'h0003); wr(5'd4, 16'h0003);
    step(0); step(0);
    chk("R8 even match sets", cmp[0], 1);
    step(0); step(0);
    chk("R8 odd match toggles even pin", cmp[0], 0);
    chk("R8 odd pin idle", cmp[1], 0);
    chk("R8 odd flag", chf[1], 1);
    chk("R10 cap-only pin", cmp[2], 0);
    chk("R10 cap-only flag", chf[2], 0);

    // R9 capture on channel 3 with timer 1
    do_reset();
    wr(5'd19, 16'h0019);
    wr(5'd3, 16'h1234);
    cap[3] = 1'b1; @(negedge clk); @(negedge clk);
    rd(5'd27, r); chk("R9 rising capture", r, 16'h1234);
    chk("R9 flag", chf[3], 1);
    wr(5'd3, 16'h2222);
    cap[3] = 1'b0; @(negedge clk); @(negedge clk);
    rd(5'd27, r); chk("R9 falling ignored", r, 16'h1234);
    wr(5'd19, 16'h0029);
    wr(5'd3, 16'h3333);
    cap[3] = 1'b1; @(negedge clk); @(negedge clk);
    rd(5'd27, r); chk("R9 rising ignored", r, 16'h1234);
    wr(5'd3, 16'h4444);
    cap[3] = 1'b0; @(negedge clk); @(negedge clk);
    rd(5'd27, r); chk("R9 falling capture", r, 16'h4444);
    wr(5'd19, 16'h0039);
    wr(5'd3, 16'h5555);
    cap[3] = 1'b1; @(negedge clk); @(negedge clk);
    rd(5'd27, r); chk("R9 both edges", r, 16'h5555);
    wr(5'd3, 16'h6666);
    cap[3] = 1'b0;
    wr(5'd27, 16'h7777);
    @(negedge clk);
    rd(5'd27, r); chk("R9 capture beats write", r, 16'h6666);

    // R1 internal clock and held external input
    do_reset();
    wr(5'd4, 16'h0003);
    ext[0] = 1'b1; repeat (5) @(negedge clk); ext[0] = 1'b0; @(negedge clk);
    rd(5'd2, r); chk("R1 one count per edge", r, 16'h0001);
    wr(5'd0, 16'hFFF0); wr(5'd2, 16'hFFFE);
    wr(5'd4, 16'h0001);
    repeat (6) @(negedge clk);
    wr(5'd4, 16'h0000);
    rd(5'd2, r);
    chk("R1 internal count range", (r >= 16'hFFF0 && r <= 16'hFFF8), 1);
    chk("R2 internal wrap flag", tf[0], 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule